// File: doc/BRIEF.md
# Software Device Select Unit

This block decides whether one device in a bank of identical chips answers a bus cycle. A cycle is framed by an active-low enable strobe. When the strobe falls, the unit samples two hardware chip-select lines and its own programmable select register. The result goes to a registered device-selected output, which stays unchanged until the strobe falls again.

The select register holds a software-off bit and a target page. Each chip has its own strapped page address. When software selection is on and the target equals the strap, the chip answers with no hardware select asserted. All chips share one global select line, so one cycle on that line can load the same register value into every chip. That value either points selection at one page or turns software selection off.

A write to the register is taken at the same strobe fall as the decision, and only in a chip that is selected in that cycle. The new value governs the next cycle and not the one that wrote it. The decision runs in the system clock domain. A strobe fall is the first clock edge at which the strobe is seen low after being seen high.

Top module: `dev_select_unit`

## Requirements
- R1: While reset is high and after it, `dev_sel` is 0 and `sel_reg` reads 5'h10: bit 4 (software off) is 1 and bits 3:0 (target page) are 0.
- R2: A strobe fall is a clock edge where `e_n` is sampled 0 and was sampled 1 at the previous edge. At any other edge, `dev_sel` and `sel_reg` keep their values whatever `cs1_n`, `cs2_n`, `wr_en` and `wr_data` do.
- R3: At a strobe fall with `cs1_n` low, `dev_sel` becomes 1 after that edge.
- R4: At a strobe fall with `cs2_n` low, `dev_sel` becomes 1 after that edge.
- R5: At a strobe fall with both hardware selects high, `sel_reg[4]` = 0 and `sel_reg[3:0]` = `page_addr`, `dev_sel` becomes 1.
- R6: At a strobe fall with both hardware selects high and `sel_reg[4]` = 1, `dev_sel` becomes 0 even when the target equals `page_addr`.
- R7: At a strobe fall with both hardware selects high and `sel_reg[3:0]` different from `page_addr`, `dev_sel` becomes 0.
- R8: At a strobe fall where the chip is selected and `wr_en` is 1, `sel_reg` takes `wr_data` (bit 4 software off, bits 3:0 target). A global cycle (`cs1_n` low) therefore loads every chip.
- R9: At a strobe fall where the chip is not selected, `wr_en` leaves `sel_reg` unchanged.
- R10: The decision at a strobe fall uses the register value from before any write in that same cycle. A written value affects only later cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| e_n | input | 1 | Cycle enable strobe, active low |
| cs1_n | input | 1 | Global hardware select, active low |
| cs2_n | input | 1 | Second hardware select, active low |
| wr_en | input | 1 | Write the select register in this cycle |
| wr_data | input | 5 | New register value: bit 4 software off, bits 3:0 target page |
| page_addr | input | 4 | Strapped page address of this chip |
| dev_sel | output | 1 | Registered selected result of the last strobe fall |
| sel_reg | output | 5 | Current select register contents |

## Verification
The decision is driven with cycles on each hardware select alone and with software-only cycles in three states. Those states are software off with a matching target, software on with a mismatch, and software on with a match, which separates the three terms of the select condition. A sweep over all sixteen strap values against a fixed target shows that exactly one page answers. Writes are issued in global cycles, in locally selected cycles and in unselected cycles, which shows that writes are gated by selection and that a write affects only the following cycle. Select and write activity while the strobe stays high, or stays low for several clocks, shows that sampling happens only at the falling edge.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

    localparam int unsigned PAGE_W = 4;
    localparam int unsigned REG_W  = PAGE_W + 1;

    typedef struct packed {
        logic              sw_off;
        logic [PAGE_W-1:0] target;
    } sel_cfg_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_GLB  = 2'd1,
        SRC_AUX  = 2'd2,
        SRC_SOFT = 2'd3
    } sel_src_e;

    localparam sel_cfg_t CFG_RESET = '{sw_off: 1'b1, target: '0};

    function automatic sel_src_e pick_source(
        input logic              glb_n,
        input logic              aux_n,
        input sel_cfg_t          cfg,
        input logic [PAGE_W-1:0] strap
    );
        sel_src_e src;
        if (!glb_n)
            src = SRC_GLB;
        else if (!aux_n)
            src = SRC_AUX;
        else if (!cfg.sw_off && (cfg.target == strap))
            src = SRC_SOFT;
        else
            src = SRC_NONE;
        return src;
    endfunction

endpackage

// File: rtl/dsu_fall_det.sv
module dsu_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= strobe_n;
    end

    assign fall = prev_q & ~strobe_n;
endmodule

// File: rtl/dsu_decide.sv
module dsu_decide
    import dsu_pkg::*;
(
    input  logic              glb_n,
    input  logic              aux_n,
    input  sel_cfg_t          cfg,
    input  logic [PAGE_W-1:0] strap,
    output sel_src_e          src,
    output logic              hit
);
    always_comb begin
        src = pick_source(glb_n, aux_n, cfg, strap);
        hit = (src != SRC_NONE);
    end
endmodule

// File: rtl/dsu_cfg_reg.sv
module dsu_cfg_reg
    import dsu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  sel_cfg_t din,
    output sel_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst)       cfg <= CFG_RESET;
        else if (load) cfg <= din;
    end
endmodule

// File: rtl/dev_select_unit.sv
module dev_select_unit
    import dsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              e_n,
    input  logic              cs1_n,
    input  logic              cs2_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [PAGE_W-1:0] page_addr,
    output logic              dev_sel,
    output logic [REG_W-1:0]  sel_reg
);
    logic     fall;
    logic     hit;
    sel_src_e src;
    sel_cfg_t cfg;
    sel_cfg_t cfg_din;
    logic     cfg_load;
    sel_src_e last_src;

    dsu_fall_det u_fall (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (e_n),
        .fall     (fall)
    );

    dsu_decide u_dec (
        .glb_n (cs1_n),
        .aux_n (cs2_n),
        .cfg   (cfg),
        .strap (page_addr),
        .src   (src),
        .hit   (hit)
    );

    assign cfg_din  = sel_cfg_t'(wr_data);
    assign cfg_load = fall & hit & wr_en;

    dsu_cfg_reg u_cfg (
        .clk  (clk),
        .rst  (rst),
        .load (cfg_load),
        .din  (cfg_din),
        .cfg  (cfg)
    );

    always_ff @(posedge clk) begin
        if (rst)       last_src <= SRC_NONE;
        else if (fall) last_src <= src;
    end

    assign dev_sel = (last_src != SRC_NONE);
    assign sel_reg = cfg;
endmodule

// File: rtl/dev_select_chk.sv
module dev_select_chk
    import dsu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              e_n,
    input logic              cs1_n,
    input logic              cs2_n,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [PAGE_W-1:0] page_addr,
    input logic              dev_sel,
    input logic [REG_W-1:0]  sel_reg
);
    logic e_seen;
    logic edge_now;
    logic soft_ok;

    always_ff @(posedge clk) begin
        if (rst) e_seen <= 1'b1;
        else     e_seen <= e_n;
    end

    assign edge_now = e_seen && !e_n;
    assign soft_ok  = !sel_reg[PAGE_W] && (sel_reg[PAGE_W-1:0] == page_addr);

    AST_HOLD_SEL: assert property (@(posedge clk) disable iff (rst)
        !edge_now |=> $stable(dev_sel)); // R2
    AST_HOLD_REG: assert property (@(posedge clk) disable iff (rst)
        !(edge_now && wr_en) |=> $stable(sel_reg)); // R2
    AST_GLB_SEL: assert property (@(posedge clk) disable iff (rst)
        (edge_now && !cs1_n) |=> dev_sel); // R3
    AST_AUX_SEL: assert property (@(posedge clk) disable iff (rst)
        (edge_now && !cs2_n) |=> dev_sel); // R4
    AST_SOFT_SEL: assert property (@(posedge clk) disable iff (rst)
        (edge_now && cs1_n && cs2_n && soft_ok) |=> dev_sel); // R5
    AST_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        (edge_now && cs1_n && cs2_n && !soft_ok) |=> !dev_sel); // R6
    AST_GLB_WR: assert property (@(posedge clk) disable iff (rst)
        (edge_now && !cs1_n && wr_en) |=> (sel_reg == $past(wr_data))); // R8
    AST_NOSEL_WR: assert property (@(posedge clk) disable iff (rst)
        (edge_now && cs1_n && cs2_n && !soft_ok) |=> $stable(sel_reg)); // R9
endmodule

bind dev_select_unit dev_select_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .e_n       (e_n),
    .cs1_n     (cs1_n),
    .cs2_n     (cs2_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .page_addr (page_addr),
    .dev_sel   (dev_sel),
    .sel_reg   (sel_reg)
);

// File: tb/tb_dev_select_unit.sv
module tb_dev_select_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       e_n = 1'b1;
    logic       cs1_n = 1'b1;
    logic       cs2_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = 5'h00;
    logic [3:0] page_addr = 4'h0;
    logic       dev_sel;
    logic [4:0] sel_reg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model state
    int m_prev_e = 1;
    int m_sel = 0;
    int m_off = 1;
    int m_tgt = 0;

    always #10 clk = ~clk;

    dev_select_unit dut (
        .clk(clk), .rst(rst), .e_n(e_n), .cs1_n(cs1_n), .cs2_n(cs2_n),
        .wr_en(wr_en), .wr_data(wr_data), .page_addr(page_addr),
        .dev_sel(dev_sel), .sel_reg(sel_reg)
    );

    always @(posedge clk) begin
        int decide;
        if (rst) begin
            m_prev_e = 1; m_sel = 0; m_off = 1; m_tgt = 0;
        end else begin
            if (m_prev_e == 1 && e_n == 1'b0) begin
                decide = (cs1_n == 1'b0 || cs2_n == 1'b0 ||
                          (m_off == 0 && m_tgt == int'(page_addr))) ? 1 : 0;
                if (decide == 1 && wr_en == 1'b1) begin
                    m_off = int'(wr_data[4]);
                    m_tgt = int'(wr_data[3:0]);
                end
                m_sel = decide;
            end
            m_prev_e = int'(e_n);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk({tag, " dev_sel"}, int'(dev_sel), m_sel);
            chk({tag, " sel_reg"}, int'(sel_reg), m_off * 16 + m_tgt);
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic bus_cycle(input logic c1, input logic c2, input logic w,
                             input logic [4:0] d, input int low_clks);
        @(negedge clk);
        cs1_n = c1; cs2_n = c2; wr_en = w; wr_data = d; e_n = 1'b0;
        repeat (low_clks) @(negedge clk);
        e_n = 1'b1; cs1_n = 1'b1; cs2_n = 1'b1; wr_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("R1 dev_sel in reset", int'(dev_sel), 0);
        chk("R1 sel_reg in reset", int'(sel_reg), 'h10);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sel_reg after reset", int'(sel_reg), 'h10);

        // software off, target matches strap 0
        tag = "R6";
        bus_cycle(1, 1, 0, 5'h00, 1);
        chk("R6 off with match", int'(dev_sel), 0);

        tag = "R3";
        bus_cycle(0, 1, 0, 5'h00, 1);
        chk("R3 global select", int'(dev_sel), 1);
        tag = "R4";
        bus_cycle(1, 0, 0, 5'h00, 1);
        chk("R4 second select", int'(dev_sel), 1);

        // unselected write attempt
        tag = "R9";
        bus_cycle(1, 1, 1, 5'h00, 1);
        chk("R9 unselected write", int'(sel_reg), 'h10);

        // while strobe stays high, activity is ignored
        tag = "R2";
        @(negedge clk);
        cs1_n = 1'b0; wr_en = 1'b1; wr_data = 5'h03;
        repeat (4) @(negedge clk);
        cs1_n = 1'b1; wr_en = 1'b0;
        chk("R2 no strobe write", int'(sel_reg), 'h10);
        chk("R2 no strobe select", int'(dev_sel), 0);

        // global write enables software selection of page 3
        tag = "R8";
        bus_cycle(0, 1, 1, 5'h03, 1);
        chk("R8 global write", int'(sel_reg), 'h03);

        tag = "R7";
        page_addr = 4'h5;
        bus_cycle(1, 1, 0, 5'h00, 1);
        chk("R7 mismatch", int'(dev_sel), 0);

        tag = "R5";
        page_addr = 4'h3;
        bus_cycle(1, 1, 0, 5'h00, 1);
        chk("R5 software match", int'(dev_sel), 1);

        // strobe held low: only one sample, later changes ignored
        tag = "R2";
        @(negedge clk);
        e_n = 1'b0;
        @(negedge clk);
        page_addr = 4'h9; cs2_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 held low", int'(dev_sel), 1);
        e_n = 1'b1;
        @(negedge clk);
        page_addr = 4'h3;

        // local write by selected chip; decision uses old value
        tag = "R10";
        bus_cycle(1, 1, 1, 5'h07, 1);
        chk("R10 writing cycle selected", int'(dev_sel), 1);
        chk("R10 new value loaded", int'(sel_reg), 'h07);
        bus_cycle(1, 1, 0, 5'h00, 1);
        chk("R10 next cycle uses new target", int'(dev_sel), 0);

        // sweep straps against target 9
        tag = "R5";
        bus_cycle(0, 1, 1, 5'h09, 2);
        for (int p = 0; p < 16; p++) begin
            page_addr = 4'(p);
            bus_cycle(1, 1, 0, 5'h00, 1);
            chk(p == 9 ? "R5 sweep hit" : "R7 sweep miss", int'(dev_sel), p == 9 ? 1 : 0);
        end

        // global write turns software selection off
        tag = "R6";
        page_addr = 4'h9;
        bus_cycle(0, 1, 1, 5'h19, 1);
        bus_cycle(1, 1, 0, 5'h00, 1);
        chk("R6 turned off", int'(dev_sel), 0);

        // second select writes too
        tag = "R8";
        bus_cycle(1, 0, 1, 5'h09, 1);
        chk("R8 aux write", int'(sel_reg), 'h09);

        // reset mid-run
        tag = "R1";
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset again sel_reg", int'(sel_reg), 'h10);
        chk("R1 reset again dev_sel", int'(dev_sel), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule